// File: doc/BRIEF.md
# Seven-to-One Pixel Frame Aligner

The aligner sits behind a bit sampler that delivers, on every pixel clock, one 7-bit word for each of four data lanes and one 7-bit word for the clock lane. Because the sampler does not know where a pixel frame begins, a frame usually straddles two consecutive words. The block keeps the previous word of every lane and forms a 14-bit window. It tests all seven bit offsets of the clock-lane window against the frame marker and locks to the offset that repeats. It then cuts the four data lanes at that same offset to form a 28-bit frame.

The frame is decoded into 8-bit red, green and blue values plus horizontal sync, vertical sync and data enable. Two packings are supported and can be selected at run time. One sends the low six bits of each color on the first three lanes and the top two bits on the fourth lane. The other swaps which bits go where. A strobe marks each decoded pixel, and a flag reports whether the aligner holds a lock.

Top module: `lvds_frame_aligner`

## Requirements
- R1: While `rst_n` is low, and right after it is released, `locked`, `pix_valid` and every pixel output are 0.
- R2: Bit 6 of every input word is the earliest bit received. The window is {previous word, current word}, with bit 13 the earliest. Offset k (0 to 6) takes window bits 13-k down to 7-k as the frame slice, and slot s of a slice is its bit 6-s. Frames are recovered correctly at every one of the seven word skews.
- R3: A frame matches when its clock-lane slice is 1100011, read from slot 0 to slot 6. While unlocked, `locked` rises at the clock edge of the 8th consecutive matching frame at a single offset.
- R4: While locked, the offset does not change. Up to 3 consecutive non-matching frames keep the lock, and the 4th consecutive miss clears `locked` at that edge.
- R5: `pix_valid` is high after an edge only if `locked` is high after that edge and the frame taken at that edge matches. It is never high while `locked` is low.
- R6: With `map_sel`=0, data bits are numbered linearly: index i = 7*lane + slot for lanes 0 to 2. Indices 0-5 are R[5:0], 6-11 are G[5:0], 12-17 are B[5:0], and 18, 19, 20 are HS, VS, DE. On lane 3, slots 0-1 carry R[7:6], slots 2-3 carry G[7:6], slots 4-5 carry B[7:6], and slot 6 is unused.
- R7: With `map_sel`=1, the same positions carry R[7:2], G[7:2] and B[7:2] on indices 0-17, HS/VS/DE stay at 18-20, and lane 3 carries R[1:0], G[1:0] and B[1:0] in the same slots.
- R8: `map_sel` may change while locked, and it applies to the frame taken at the next edge.
- R9: The pixel outputs and `pix_valid` update at the same clock edge at which the word completing the frame is sampled. When `pix_valid` is low, the pixel outputs hold their last value.
- R10: While unlocked, a non-matching frame restarts the count of consecutive matches, so lock needs 8 fresh matches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| clk_word | input | 7 | Clock-lane bits for this cycle, bit 6 earliest |
| data_word | input | 28 | Four data lanes, lane n in bits 7n+6..7n, bit 6 of each earliest |
| map_sel | input | 1 | Color packing select: 0 low bits on lanes 0-2, 1 high bits on lanes 0-2 |
| pix_r | output | 8 | Red |
| pix_g | output | 8 | Green |
| pix_b | output | 8 | Blue |
| pix_hs | output | 1 | Horizontal sync |
| pix_vs | output | 1 | Vertical sync |
| pix_de | output | 1 | Data enable |
| pix_valid | output | 1 | Decoded pixel strobe |
| locked | output | 1 | Frame alignment held |

## Verification
Every result is due at the first edge after the word that completes its frame, and that edge also moves `locked`. The bench therefore drives the word for step n on a falling edge and lets one rising edge pass. It then compares `locked`, `pix_valid` and the pixel against the frame index and match flag that its own stream generator predicts for that step. The lock and miss counts are modelled in the bench directly from the thresholds in the requirements. The sweep covers every skew and both starting packings, with a packing switch late in each run.

// File: rtl/lvds_fa_pkg.sv
package lvds_fa_pkg;
   localparam int unsigned FA_SLOTS = 7;
   localparam int unsigned FA_LANES = 4;
   localparam logic [FA_SLOTS-1:0] FA_MARKER = 7'b1100011;

   typedef struct packed {
      logic [7:0] r;
      logic [7:0] g;
      logic [7:0] b;
      logic       hs;
      logic       vs;
      logic       de;
   } fa_pixel_t;
endpackage

// File: rtl/lvds_fa_rot_pick.sv
module lvds_fa_rot_pick #(
   parameter int unsigned W  = 7,
   localparam int unsigned RW = $clog2(W)
) (
   input  logic [W-1:0]  prev_w,
   input  logic [W-1:0]  cur_w,
   input  logic [RW-1:0] rot,
   output logic [W-1:0]  slice
);
   logic [2*W-1:0] win;
   int unsigned    top_i;

   always_comb begin
      win   = {prev_w, cur_w};
      top_i = (2*W-1) - int'(rot);
      slice = win[top_i -: W];
   end
endmodule

// File: rtl/lvds_fa_lock.sv
module lvds_fa_lock #(
   parameter int unsigned W          = 7,
   parameter logic [W-1:0] MARKER    = 7'b1100011,
   parameter int unsigned LOCK_CNT   = 8,
   parameter int unsigned UNLOCK_CNT = 4,
   localparam int unsigned RW = $clog2(W),
   localparam int unsigned GW = $clog2(LOCK_CNT + 1),
   localparam int unsigned BW = $clog2(UNLOCK_CNT + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [W-1:0]  prev_c,
   input  logic [W-1:0]  cur_c,
   output logic [RW-1:0] rot_q,
   output logic          locked_q,
   output logic          take
);
   generate
      if (LOCK_CNT < 2) begin : g_chk_lock
         $error("LOCK_CNT must be at least 2");
      end
      if (UNLOCK_CNT < 1) begin : g_chk_unlock
         $error("UNLOCK_CNT must be at least 1");
      end
   endgenerate

   logic [2*W-1:0] win;
   logic [W-1:0]   match;
   logic [RW-1:0]  hit_idx, rot_d;
   logic           hit_any, at_rot, locked_d;
   logic [GW-1:0]  good_q, good_d;
   logic [BW-1:0]  bad_q, bad_d;

   assign win = {prev_c, cur_c};

   for (genvar k = 0; k < W; k++) begin : g_off
      assign match[k] = (win[2*W-1-k -: W] == MARKER);
   end

   always_comb begin
      hit_idx = '0;
      for (int i = W - 1; i >= 0; i--) begin
         if (match[i]) hit_idx = RW'(i);
      end
   end

   assign hit_any = |match;
   assign at_rot  = match[rot_q];

   always_comb begin
      rot_d    = rot_q;
      locked_d = locked_q;
      good_d   = good_q;
      bad_d    = bad_q;
      if (!locked_q) begin
         if (hit_any && hit_idx == rot_q) begin
            if (good_q == GW'(LOCK_CNT - 1)) begin
               locked_d = 1'b1;
               good_d   = '0;
            end else begin
               good_d = good_q + 1'b1;
            end
         end else if (hit_any) begin
            rot_d  = hit_idx;
            good_d = GW'(1);
         end else begin
            good_d = '0;
         end
      end else if (at_rot) begin
         bad_d = '0;
      end else if (bad_q == BW'(UNLOCK_CNT - 1)) begin
         locked_d = 1'b0;
         bad_d    = '0;
         good_d   = '0;
      end else begin
         bad_d = bad_q + 1'b1;
      end
   end

   assign take = locked_d && at_rot;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rot_q    <= '0;
         locked_q <= 1'b0;
         good_q   <= '0;
         bad_q    <= '0;
      end else begin
         rot_q    <= rot_d;
         locked_q <= locked_d;
         good_q   <= good_d;
         bad_q    <= bad_d;
      end
   end

   logic at_rot_q;
   always_ff @(posedge clk) begin
      if (!rst_n) at_rot_q <= 1'b0;
      else        at_rot_q <= at_rot;
   end

   // R3: lock only rises on a matching frame
   a_r3_rise_on_match: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(locked_q) |-> at_rot_q);
   // R4: lock only falls on a missing frame
   a_r4_fall_on_miss: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(locked_q) |-> !at_rot_q);
   // R4: offset frozen while locked
   a_r4_rot_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      (locked_q && $past(locked_q)) |-> $stable(rot_q));
   // R3: run counter stays below threshold
   a_r3_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
      good_q < GW'(LOCK_CNT));
   // R4: miss counter stays below threshold
   a_r4_miss_bound: assert property (@(posedge clk) disable iff (!rst_n)
      bad_q < BW'(UNLOCK_CNT));
endmodule

// File: rtl/lvds_fa_unpack.sv
module lvds_fa_unpack
   import lvds_fa_pkg::*;
#(
   parameter int unsigned W = FA_SLOTS
) (
   input  logic [4*W-1:0] frame,
   input  logic           map_sel,
   output fa_pixel_t      px
);
   generate
      if (W != 7) begin : g_chk_w
         $error("unpack layout needs 7 slots per lane");
      end
   endgenerate

   logic [3*W-1:0] lin;
   logic [5:0]     ext;
   logic [5:0]     cr, cg, cb;

   always_comb begin
      for (int i = 0; i < 3 * W; i++) begin
         lin[i] = frame[(i / W) * W + (W - 1) - (i % W)];
      end
      for (int s = 0; s < 6; s++) begin
         ext[s] = frame[3 * W + (W - 1) - s];
      end
      cr = lin[5:0];
      cg = lin[11:6];
      cb = lin[17:12];
      px.hs = lin[18];
      px.vs = lin[19];
      px.de = lin[20];
      if (!map_sel) begin
         px.r = {ext[1:0], cr};
         px.g = {ext[3:2], cg};
         px.b = {ext[5:4], cb};
      end else begin
         px.r = {cr, ext[1:0]};
         px.g = {cg, ext[3:2]};
         px.b = {cb, ext[5:4]};
      end
   end
endmodule

// File: rtl/lvds_frame_aligner.sv
module lvds_frame_aligner
   import lvds_fa_pkg::*;
#(
   parameter int unsigned LOCK_CNT   = 8,
   parameter int unsigned UNLOCK_CNT = 4,
   localparam int unsigned W  = FA_SLOTS,
   localparam int unsigned NL = FA_LANES,
   localparam int unsigned RW = $clog2(W)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [W-1:0]    clk_word,
   input  logic [NL*W-1:0] data_word,
   input  logic            map_sel,
   output logic [7:0]      pix_r,
   output logic [7:0]      pix_g,
   output logic [7:0]      pix_b,
   output logic            pix_hs,
   output logic            pix_vs,
   output logic            pix_de,
   output logic            pix_valid,
   output logic            locked
);
   logic [W-1:0]    clk_prev;
   logic [NL*W-1:0] data_prev;
   logic [RW-1:0]   rot;
   logic            take;
   logic [NL*W-1:0] frame;
   fa_pixel_t       px;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         clk_prev  <= '0;
         data_prev <= '0;
      end else begin
         clk_prev  <= clk_word;
         data_prev <= data_word;
      end
   end

   lvds_fa_lock #(
      .W(W), .MARKER(FA_MARKER), .LOCK_CNT(LOCK_CNT), .UNLOCK_CNT(UNLOCK_CNT)
   ) u_lock (
      .clk(clk), .rst_n(rst_n), .prev_c(clk_prev), .cur_c(clk_word),
      .rot_q(rot), .locked_q(locked), .take(take)
   );

   for (genvar l = 0; l < NL; l++) begin : g_lane
      lvds_fa_rot_pick #(.W(W)) u_pick (
         .prev_w(data_prev[l*W +: W]),
         .cur_w (data_word[l*W +: W]),
         .rot   (rot),
         .slice (frame[l*W +: W])
      );
   end

   lvds_fa_unpack #(.W(W)) u_unpack (
      .frame(frame), .map_sel(map_sel), .px(px)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         {pix_r, pix_g, pix_b, pix_hs, pix_vs, pix_de} <= '0;
         pix_valid <= 1'b0;
      end else begin
         pix_valid <= take;
         if (take) begin
            pix_r  <= px.r;
            pix_g  <= px.g;
            pix_b  <= px.b;
            pix_hs <= px.hs;
            pix_vs <= px.vs;
            pix_de <= px.de;
         end
      end
   end

   // R5: strobe never without lock
   a_r5_valid_needs_lock: assert property (@(posedge clk) disable iff (!rst_n)
      pix_valid |-> locked);
   // R9: outputs hold when no pixel is taken
   a_r9_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !pix_valid |-> $stable(pix_r) && $stable(pix_g) && $stable(pix_b));
endmodule

// File: tb/lvds_frame_aligner_bench.sv
module lvds_frame_aligner_bench;
   logic        clk = 1'b0;
   logic        rst_n;
   logic [6:0]  clk_word;
   logic [27:0] data_word;
   logic        map_sel;
   logic [7:0]  pix_r, pix_g, pix_b;
   logic        pix_hs, pix_vs, pix_de, pix_valid, locked;

   always #4 clk = ~clk;

   lvds_frame_aligner u_lvds_frame_aligner (
      .clk(clk), .rst_n(rst_n), .clk_word(clk_word), .data_word(data_word),
      .map_sel(map_sel), .pix_r(pix_r), .pix_g(pix_g), .pix_b(pix_b),
      .pix_hs(pix_hs), .pix_vs(pix_vs), .pix_de(pix_de),
      .pix_valid(pix_valid), .locked(locked)
   );

   int checks = 0;
   int fails  = 0;
   bit done   = 0;
   int sk;
   bit cfg_map;

   localparam logic [6:0] MARK = 7'b1100011;

   function automatic bit corrupt(int j);
      return (j == 20 || j == 21 || j == 22 || j == 30 || j == 31 ||
              j == 32 || j == 33 || j == 40);
   endfunction

   function automatic bit fmap(int j);
      return cfg_map ^ (j >= 52);
   endfunction

   function automatic logic [7:0] er(int j); return 8'((j * 29 + sk * 3 + 7) & 255); endfunction
   function automatic logic [7:0] eg(int j); return 8'((j * 53 + 91) & 255); endfunction
   function automatic logic [7:0] eb(int j); return 8'(j * 17) ^ 8'hA5; endfunction

   // builds one lane slice per R6/R7, slot s at bit 6-s
   function automatic logic [6:0] lane_frame(int l, int j, bit m);
      logic [7:0]  r, g, b;
      logic [17:0] core;
      logic [5:0]  ext;
      logic [20:0] lin;
      logic [6:0]  f;
      r = er(j); g = eg(j); b = eb(j);
      if (!m) begin
         core = {b[5:0], g[5:0], r[5:0]};
         ext  = {b[7:6], g[7:6], r[7:6]};
      end else begin
         core = {b[7:2], g[7:2], r[7:2]};
         ext  = {b[1:0], g[1:0], r[1:0]};
      end
      lin = {j[2], j[1], j[0], core};
      for (int s = 0; s < 7; s++) begin
         if (l < 3)      f[6-s] = lin[7*l + s];
         else if (s < 6) f[6-s] = ext[s];
         else            f[6-s] = 1'b0;
      end
      return f;
   endfunction

   function automatic bit stream_bit(int l, int pos);
      int j, s;
      logic [6:0] f;
      j = pos / 7;
      s = pos % 7;
      if (l == 4) return corrupt(j) ? 1'b0 : MARK[6-s];
      f = lane_frame(l, j, fmap(j));
      return f[6-s];
   endfunction

   task automatic check(bit ok, string tag, int act, int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s skew=%0d map=%0d actual=%0h expected=%0h", tag, sk, cfg_map, act, exp);
      end
   endtask

   task automatic run_cfg(bit m0, int s);
      bit lk;
      int cnt, bad, jn;
      bit good, ev;
      cfg_map = m0;
      sk = s;
      rst_n = 1'b0;
      clk_word = '0; data_word = '0; map_sel = m0;
      repeat (2) @(posedge clk);
      @(negedge clk);
      // R1: reset state
      check(locked == 0 && pix_valid == 0, "R1 flags", {locked, pix_valid}, 0);
      check({pix_r, pix_g, pix_b, pix_hs, pix_vs, pix_de} == 0, "R1 pixel",
            {pix_r, pix_g, pix_b}, 0);
      rst_n = 1'b1;
      lk = 0; cnt = 0; bad = 0;
      for (int n = 0; n < 60; n++) begin
         jn = (s > 0) ? n : n - 1;
         for (int t = 0; t < 7; t++) begin
            clk_word[6-t] = stream_bit(4, 7*n + s + t);
            for (int l = 0; l < 4; l++) data_word[7*l + 6 - t] = stream_bit(l, 7*n + s + t);
         end
         map_sel = fmap(jn);
         @(posedge clk);
         @(negedge clk);
         good = (n >= 1) && !corrupt(jn);
         if (!lk) begin
            if (good) begin
               cnt++;
               if (cnt == 8) begin lk = 1; cnt = 0; end
            end else cnt = 0;
         end else if (good) bad = 0;
         else begin
            bad++;
            if (bad == 4) begin lk = 0; bad = 0; end
         end
         ev = lk && good;
         check(locked == lk, "R3 R4 R10 locked", locked, lk);
         check(pix_valid == ev, "R5 valid", pix_valid, ev);
         if (ev) begin
            if (jn >= 52)
               check({pix_r, pix_g, pix_b} == {er(jn), eg(jn), eb(jn)}, "R8 R9 switched rgb",
                     {pix_r, pix_g, pix_b}, {er(jn), eg(jn), eb(jn)});
            else if (!m0)
               check({pix_r, pix_g, pix_b} == {er(jn), eg(jn), eb(jn)}, "R2 R6 R9 rgb",
                     {pix_r, pix_g, pix_b}, {er(jn), eg(jn), eb(jn)});
            else
               check({pix_r, pix_g, pix_b} == {er(jn), eg(jn), eb(jn)}, "R2 R7 R9 rgb",
                     {pix_r, pix_g, pix_b}, {er(jn), eg(jn), eb(jn)});
            check({pix_hs, pix_vs, pix_de} == {jn[0], jn[1], jn[2]}, "R6 R7 sync",
                  {pix_hs, pix_vs, pix_de}, {jn[0], jn[1], jn[2]});
         end
      end
   endtask

   initial begin
      for (int m = 0; m < 2; m++) begin
         for (int s = 0; s < 7; s++) run_cfg(m[0], s);
      end
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end
endmodule